// File: doc/BRIEF.md
# Sample-Queued Pulse-Width Modulator

This block drives one pulse-width modulated output whose high time per period is taken from a short queue of duty samples. Software programs a period length, a prescale ratio, a repeat factor and an output mode through a 32-bit synchronous register port. It then pushes duty samples into a four-word queue. Each sample stays active for 1, 2, 4 or 8 output periods. The next queued sample is taken at a period boundary. When the queue runs dry, the last sample stays in use.

A period lasts the programmed period value plus two prescaled ticks. One tick lasts the prescale field plus one clock cycles. In direct mode the output is high from the start of a period while the period counter is below the active sample. Complement mode inverts this, and the two dark modes hold the output low. Whenever the block is not enabled, the output is low.

Sticky event flags report an empty queue, a period rollover, a counter-equals-sample match and a dropped write. They are cleared by writing ones. A self-clearing reset command returns the whole block to its idle state. While that command is in progress, register writes have no effect.

Top module: `fifo_pwm`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0, the period register (offset 0x10) reads 0xFFFE, the status word (offset 0x04) reads 0x08 (queue empty flag at bit 3, count 0), and the output is low.
- R2: With period value P and prescale field Q (control bits 15:4), the period counter advances once every Q+1 clocks through 0..P+1. Starting at the enable write, the output in direct mode (control bits 19:18 = 0) is high exactly while the counter is below the active sample.
- R3: Output mode 1 complements the direct waveform. Modes 2 and 3 hold the output low while enabled.
- R4: While control bit 0 (enable) is 0, the output is low whatever the mode.
- R5: The write that sets enable takes the first queued sample. Each sample stays active for 1, 2, 4 or 8 periods for repeat field (control bits 2:1) values 0, 1, 2 and 3. At the end of that time the next sample is taken at the period boundary.
- R6: At a period boundary where a new sample is due but the queue is empty, the active sample is kept.
- R7: Status bits 2:0 give the number of queued samples, 0 to 4. A write to the sample register (offset 0x0C) while four samples are queued is dropped and sets status bit 6.
- R8: Status bit 4 sets on a period rollover and bit 5 when the counter equals the active sample while enabled. Bits 3 to 6 are cleared by writing 1 to them.
- R9: A period value of 0xFFFF gives the same period as 0xFFFE, namely 0x10000 ticks.
- R10: Writing control bit 3 clears the control word, the queue, the flags and the counter, and sets the period register to 0xFFFE. Bit 3 then reads 1 for 4 cycles and 0 afterwards. Writes during those cycles are ignored.
- R11: The sample register reads the active sample while enabled and 0 while disabled.
- R12: Control bits 31:20 and 17:16 read back as written and do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pwm_out | output | 1 | Modulated output |

## Verification
A wrong prescale or period counter shifts every edge of the output. The first misplaced edge appears within one period of the enable write, and the per-cycle waveform comparison catches it. A wrong repeat counter or queue pointer selects the wrong sample at the first due boundary. That shows up as a wrong high time in the period that follows. A missed period clamp never raises the rollover flag at the expected cycle. A wrong busy counter shows up in the reset bit's readback on the cycle it should change.

// File: rtl/fifo_pwm_pkg.sv
package fifo_pwm_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] A_SMP  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_PER  = 5'h10;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_RPT  = 1;
  localparam int unsigned RPT_W   = 2;
  localparam int unsigned CB_SWR  = 3;
  localparam int unsigned CB_PSC  = 4;
  localparam int unsigned CB_MODE = 18;
  localparam int unsigned SB_FLAG = 3;
  localparam int unsigned N_FLAGS = 4;

  typedef enum logic [1:0] {
    OM_DIRECT = 2'd0,
    OM_COMPL  = 2'd1,
    OM_DARK   = 2'd2,
    OM_DARK2  = 2'd3
  } out_mode_e;
endpackage

// File: rtl/fifo_pwm_fifo.sv
module fifo_pwm_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FCW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           push,
  input  logic           pop,
  input  logic [DW-1:0]  din,
  output logic [DW-1:0]  dout,
  output logic [FCW-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [FCW-1:0]   cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push && !clr;
  assign do_pop  = pop && !clr && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wp_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem[g] <= din;
    end
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/fifo_pwm_core.sv
module fifo_pwm_core
  import fifo_pwm_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 12,
  localparam int unsigned REP_W = (1 << RPT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             en,
  input  logic [RPT_W-1:0] rpt,
  input  logic [PW-1:0]    psc,
  input  logic [CW-1:0]    per_eff,
  input  out_mode_e        mode,
  input  logic             fifo_nz,
  input  logic [CW-1:0]    fifo_dout,
  output logic             pop,
  output logic [CW-1:0]    active,
  output logic [CW-1:0]    cnt,
  output logic             roll,
  output logic             cmp_hit,
  output logic             pwm_out
);
  logic [PW-1:0]    div_q, div_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CW-1:0]    act_q, act_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [REP_W-1:0] rep_last;
  logic [CW-1:0]    per_end;
  logic             tick, level;

  assign rep_last = REP_W'((32'd1 << rpt) - 32'd1);
  assign per_end  = per_eff + 1'b1;
  assign tick     = en && (div_q == psc);
  assign roll     = tick && (cnt_q >= per_end);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    rep_d = rep_q;
    act_d = act_q;
    pop   = 1'b0;
    if (clr) begin
      div_d = '0;
      cnt_d = '0;
      rep_d = '0;
      act_d = '0;
    end else if (start) begin
      div_d = '0;
      cnt_d = '0;
      rep_d = '0;
      if (fifo_nz) begin
        pop   = 1'b1;
        act_d = fifo_dout;
      end
    end else if (!en) begin
      div_d = '0;
      cnt_d = '0;
      rep_d = '0;
    end else if (tick) begin
      div_d = '0;
      if (roll) begin
        cnt_d = '0;
        if (rep_q == rep_last) begin
          rep_d = '0;
          if (fifo_nz) begin
            pop   = 1'b1;
            act_d = fifo_dout;
          end
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      rep_q <= '0;
      act_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      rep_q <= rep_d;
      act_q <= act_d;
    end
  end

  assign level   = (cnt_q < act_q);
  assign cmp_hit = en && (cnt_q == act_q);

  always_comb begin
    pwm_out = 1'b0;
    if (en) begin
      case (mode)
        OM_DIRECT: pwm_out = level;
        OM_COMPL:  pwm_out = !level;
        default:   pwm_out = 1'b0;
      endcase
    end
  end

  assign active = act_q;
  assign cnt    = cnt_q;
endmodule

// File: rtl/fifo_pwm_regs.sv
module fifo_pwm_regs
  import fifo_pwm_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned PW         = 12,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned FCW = $clog2(DEPTH + 1),
  localparam int unsigned BW  = $clog2(RST_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [FCW-1:0]     fifo_cnt,
  input  logic [CW-1:0]      active,
  input  logic               roll,
  input  logic               cmp_hit,
  output logic               en,
  output logic [RPT_W-1:0]   rpt,
  output logic [PW-1:0]      psc,
  output out_mode_e          mode,
  output logic [CW-1:0]      per_eff,
  output logic               start,
  output logic               clr,
  output logic               push,
  output logic [CW-1:0]      push_data,
  output logic [N_FLAGS-1:0] flags,
  output logic               busy
);
  localparam logic [CW-1:0]  PER_CAP  = {{(CW-1){1'b1}}, 1'b0};
  localparam logic [CW-1:0]  PER_ONES = '1;
  localparam logic [FCW-1:0] FULL     = FCW'(DEPTH);
  localparam logic [BW-1:0]  BUSY_LD  = BW'(RST_CYCLES);

  logic [BUS_DW-1:0]  ctrl_q, ctrl_d;
  logic [CW-1:0]      per_q, per_d;
  logic [N_FLAGS-1:0] flg_q, flg_d, flg_set, flg_w1c;
  logic [BW-1:0]      bsy_q, bsy_d;
  logic               wr, wr_ctrl, wr_stat, wr_smp, wr_per, swr_go, fwe_set;

  assign busy    = (bsy_q != '0);
  assign wr      = bus_en && bus_we && !busy;
  assign wr_ctrl = wr && (bus_addr == A_CTRL);
  assign wr_stat = wr && (bus_addr == A_STAT);
  assign wr_smp  = wr && (bus_addr == A_SMP);
  assign wr_per  = wr && (bus_addr == A_PER);
  assign swr_go  = wr_ctrl && bus_wdata[CB_SWR];
  assign start   = wr_ctrl && !swr_go && bus_wdata[CB_EN] && !ctrl_q[CB_EN];
  assign clr     = swr_go || busy;
  assign push    = wr_smp && (fifo_cnt < FULL);
  assign fwe_set = wr_smp && (fifo_cnt >= FULL);
  assign push_data = bus_wdata[CW-1:0];

  // flag order: [0] queue empty, [1] rollover, [2] compare, [3] dropped write
  assign flg_set = {fwe_set, cmp_hit, roll, (fifo_cnt == '0)};
  assign flg_w1c = wr_stat ? bus_wdata[SB_FLAG +: N_FLAGS] : '0;

  always_comb begin
    ctrl_d = ctrl_q;
    per_d  = per_q;
    flg_d  = (flg_q & ~flg_w1c) | flg_set;
    bsy_d  = busy ? bsy_q - 1'b1 : bsy_q;
    if (swr_go) begin
      ctrl_d = '0;
      per_d  = PER_CAP;
      flg_d  = '0;
      bsy_d  = BUSY_LD;
    end else begin
      if (wr_ctrl) begin
        ctrl_d         = bus_wdata;
        ctrl_d[CB_SWR] = 1'b0;
      end
      if (wr_per) per_d = bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= PER_CAP;
      flg_q  <= '0;
      bsy_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      per_q  <= per_d;
      flg_q  <= flg_d;
      bsy_q  <= bsy_d;
    end
  end

  assign en      = ctrl_q[CB_EN];
  assign rpt     = ctrl_q[CB_RPT +: RPT_W];
  assign psc     = ctrl_q[CB_PSC +: PW];
  assign mode    = out_mode_e'(ctrl_q[CB_MODE +: 2]);
  assign per_eff = (per_q == PER_ONES) ? PER_CAP : per_q;
  assign flags   = flg_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata         = ctrl_q;
        bus_rdata[CB_SWR] = busy;
      end
      A_STAT: begin
        bus_rdata[2:0]                = 3'(fifo_cnt);
        bus_rdata[SB_FLAG +: N_FLAGS] = flg_q;
      end
      A_SMP:   bus_rdata[CW-1:0] = en ? active : '0;
      A_PER:   bus_rdata[CW-1:0] = per_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
  import fifo_pwm_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned PW         = 12,
  parameter int unsigned DEPTH      = 4,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned SYNC       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              pwm_out
);
  localparam int unsigned FCW = $clog2(DEPTH + 1);

  logic [SYNC-1:0]    rs_q;
  logic               rst_s_n;
  logic               en_w, start_w, clr_w, push_w, pop_w, roll_w, cmp_w, busy_w;
  logic [RPT_W-1:0]   rpt_w;
  logic [PW-1:0]      psc_w;
  out_mode_e          omode_w;
  logic [CW-1:0]      per_eff_w, push_data_w, fifo_dout_w, active_w, cnt_w;
  logic [FCW-1:0]     fifo_cnt_w;
  logic [N_FLAGS-1:0] flags_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC-2:0], 1'b1};
  end
  assign rst_s_n = rs_q[SYNC-1];

  fifo_pwm_regs #(.CW(CW), .PW(PW), .DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fifo_cnt(fifo_cnt_w), .active(active_w), .roll(roll_w), .cmp_hit(cmp_w),
    .en(en_w), .rpt(rpt_w), .psc(psc_w), .mode(omode_w), .per_eff(per_eff_w),
    .start(start_w), .clr(clr_w), .push(push_w), .push_data(push_data_w),
    .flags(flags_w), .busy(busy_w)
  );

  fifo_pwm_fifo #(.DW(CW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n), .clr(clr_w),
    .push(push_w), .pop(pop_w), .din(push_data_w),
    .dout(fifo_dout_w), .count(fifo_cnt_w)
  );

  fifo_pwm_core #(.CW(CW), .PW(PW)) u_core (
    .clk(clk), .rst_n(rst_s_n), .clr(clr_w), .start(start_w), .en(en_w),
    .rpt(rpt_w), .psc(psc_w), .per_eff(per_eff_w), .mode(omode_w),
    .fifo_nz(fifo_cnt_w != '0), .fifo_dout(fifo_dout_w),
    .pop(pop_w), .active(active_w), .cnt(cnt_w), .roll(roll_w),
    .cmp_hit(cmp_w), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk
  import fifo_pwm_pkg::*;
#(
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned FCW = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [BUS_DW-1:0]  bus_wdata,
  input logic               pwm_out,
  input logic               en,
  input out_mode_e          omode,
  input logic [FCW-1:0]     fifo_cnt,
  input logic [CW-1:0]      cnt,
  input logic               roll,
  input logic [CW-1:0]      active,
  input logic [N_FLAGS-1:0] flags,
  input logic               busy
);
  logic wr_free, ctrl_wr, swr_wr, full_wr;
  assign wr_free = bus_en && bus_we && !busy;
  assign ctrl_wr = wr_free && (bus_addr == A_CTRL);
  assign swr_wr  = ctrl_wr && bus_wdata[CB_SWR];
  assign full_wr = wr_free && (bus_addr == A_SMP) && (fifo_cnt == FCW'(DEPTH));

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  a_r3_dark_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && omode[1]) |-> !pwm_out);

  a_r7_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FCW'(DEPTH));

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr |=> flags[3]);

  a_r2_roll_zero: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (cnt == '0));

  a_r6_keep_last: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && (fifo_cnt == '0) && !busy && !ctrl_wr) |=> $stable(active));

  a_r10_swr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    swr_wr |=> (busy && (fifo_cnt == '0) && !en));
endmodule

bind fifo_pwm fifo_pwm_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_out(pwm_out),
  .en(en_w), .omode(omode_w), .fifo_cnt(fifo_cnt_w), .cnt(cnt_w),
  .roll(roll_w), .active(active_w), .flags(flags_w), .busy(busy_w)
);

// File: tb/fifo_pwm_tb.sv
module fifo_pwm_tb;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_SMP  = 5'h0C;
  localparam logic [4:0] A_PER  = 5'h10;
  localparam int RST_CYC = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        pwm_out;

  int n_chk;
  int n_fail;
  bit done;

  fifo_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 32'h8);
    repeat (RST_CYC + 1) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int plist [4];
    int smp [4];
    int p, per, rep, ncyc, t, c, m, idx;
    logic e;
    plist = '{0, 1, 3, 6};
    n_chk = 0; n_fail = 0; done = 1'b0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_PER, v);  chk("R1 period", v, 32'hFFFE);
    rd(A_STAT, v); chk("R1 status", v, 32'h08);
    chk("R1 out", {31'b0, pwm_out}, 32'h0);

    // R7 count and dropped write, R8 W1C, R11 sample read while disabled
    soft_reset();
    for (int i = 0; i < 5; i++) wr(A_SMP, 32'(i + 1));
    rd(A_STAT, v); chk("R7 full status", v, 32'h4C);
    wr(A_STAT, 32'h48);
    rd(A_STAT, v); chk("R8 w1c", v, 32'h04);
    rd(A_SMP, v);  chk("R11 disabled read", v, 32'h0);

    // R12 stored-only fields
    wr(A_CTRL, 32'hFFF3_0000);
    rd(A_CTRL, v); chk("R12 readback", v, 32'hFFF3_0000);
    chk("R12 out", {31'b0, pwm_out}, 32'h0);

    // R10 software reset
    wr(A_SMP, 32'h7);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v); chk("R10 busy bit", v, 32'h8);
    wr(A_PER, 32'h5);
    repeat (3) @(negedge clk);
    rd(A_CTRL, v); chk("R10 bit cleared", v, 32'h0);
    rd(A_PER, v);  chk("R10 write ignored", v, 32'hFFFE);
    rd(A_STAT, v); chk("R10 queue flushed", v & 32'h7, 32'h0);

    // R8 compare and rollover, R11 enabled read
    soft_reset();
    wr(A_PER, 32'd9);
    wr(A_SMP, 32'd3);
    wr(A_STAT, 32'h78);
    wr(A_CTRL, 32'h1);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R8 cmp before", v & 32'h20, 32'h0);
    @(negedge clk);
    rd(A_STAT, v); chk("R8 cmp set", v & 32'h20, 32'h20);
    rd(A_SMP, v);  chk("R11 enabled read", v, 32'd3);
    repeat (6) @(negedge clk);
    rd(A_STAT, v); chk("R8 rov before", v & 32'h10, 32'h0);
    @(negedge clk);
    rd(A_STAT, v); chk("R8 rov set", v & 32'h10, 32'h10);

    // R4 disabled output low in complement mode
    soft_reset();
    wr(A_SMP, 32'd0);
    wr(A_CTRL, 32'h1 | (32'd1 << 18));
    chk("R3 complement high", {31'b0, pwm_out}, 32'h1);
    wr(A_CTRL, 32'd1 << 18);
    chk("R4 disabled low", {31'b0, pwm_out}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R4 disabled stays low", {31'b0, pwm_out}, 32'h0);

    // R2 R3 R5 R6 sweep
    for (int pi = 0; pi < 4; pi++)
      for (int d = 1; d <= 3; d++)
        for (int r = 0; r < 4; r++)
          for (int md = 0; md < 3; md++) begin
            p = plist[pi];
            per = p + 2;
            rep = 1 << r;
            smp = '{1, per, 0, (per + 1) / 2};
            soft_reset();
            wr(A_PER, 32'(p));
            for (int i = 0; i < 4; i++) wr(A_SMP, 32'(smp[i]));
            wr(A_CTRL, 32'h1 | 32'(r << 1) | 32'((d - 1) << 4) | 32'(md << 18));
            ncyc = d * per * rep * 5;
            for (int k = 0; k < ncyc; k++) begin
              if (k > 0) @(negedge clk);
              t = k / d;
              c = t % per;
              m = t / per;
              idx = m / rep;
              if (idx > 3) idx = 3;
              if (md == 0)      e = (c < smp[idx]);
              else if (md == 1) e = !(c < smp[idx]);
              else              e = 1'b0;
              chk($sformatf("R2 R3 R5 R6 p=%0d d=%0d r=%0d md=%0d k=%0d", p, d, r, md, k),
                  {31'b0, pwm_out}, {31'b0, e});
            end
          end

    // R9 period clamp
    soft_reset();
    wr(A_PER, 32'hFFFF);
    wr(A_SMP, 32'd5);
    wr(A_STAT, 32'h78);
    wr(A_CTRL, 32'h1);
    rd(A_PER, v); chk("R9 readback", v, 32'hFFFF);
    repeat (65535) @(negedge clk);
    rd(A_STAT, v); chk("R9 rov before", v & 32'h10, 32'h0);
    @(negedge clk);
    rd(A_STAT, v); chk("R9 rov at 0x10000", v & 32'h10, 32'h10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule